// File: doc/BRIEF.md
# Clean-Page Write Fault Entry

This block sits beside a set-associative TLB and watches each access's lookup result. When a write hits a valid entry, passes the access-rights check and finds that entry's dirty flag still clear, the block takes the exception. It does this in a single clock edge. It records the faulting context into its own control registers, builds the updated status word, and hands fetch a new target that lies a fixed distance past the vector base. A one-cycle taken pulse marks the edge so that the pipeline can flush.

The block's outputs are the registers a handler later reads. These are the page-entry-high word (the faulting page number), the fault address, the event code, the saved PC, the saved status and the replacement-way index. A small register-write port lets software overwrite the entry-high word, the entry-low word and the way index. A load command presents both entry words and the chosen way to the TLB for a reload.

Top module: `wfault_entry`

## Requirements
- R1: An exception is taken only when acc_vld, acc_wr, tlb_hit, tlb_valid and tlb_rights_ok are all 1, tlb_dirty is 0 and the mask bit is clear. A read, a miss, an invalid entry, a rights failure or a dirty entry takes none.
- R2: On entry, ent_hi receives the faulting address with its low PG offset bits forced to zero, which leaves only the page number.
- R3: On entry, fault_addr receives the whole faulting address.
- R4: On entry, evt_code is loaded with 0x080. It resets to 0.
- R5: On entry, saved_pc receives cur_pc. If in_dslot is 1, it receives br_pc instead.
- R6: On entry, saved_sr receives sr_in as it was in the faulting cycle.
- R7: On entry, sr_out receives sr_in with bits 30 (privileged mode), 29 (register bank) and 28 (mask) set to 1. All other bits are copied unchanged.
- R8: On entry, repl_way receives tlb_way.
- R9: On entry, redir_pc receives vbr + 0x100.
- R10: While sr_in bit 28 is 1, no exception is taken and no captured register changes.
- R11: All captures occur on the same edge as the rising of exc_taken. exc_taken stays high for one cycle per faulting access.
- R12: A software write with sw_we=1 targets a register by sw_sel: 0 writes ent_hi, 1 writes ent_lo, and 2 writes repl_way from the low bits of sw_wdata. Code 3 writes nothing. In the cycle an exception is taken, the capture wins over a software write to ent_hi or repl_way.
- R13: tlb_we follows ldtlb in the same cycle. During that cycle, tlb_wway shows repl_way, tlb_hi shows ent_hi and tlb_lo shows ent_lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | An access is presented this cycle |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | AW | Logical address of the access |
| tlb_hit | input | 1 | Address matched a TLB entry |
| tlb_valid | input | 1 | Matched entry is valid |
| tlb_rights_ok | input | 1 | Access rights permit the access |
| tlb_dirty | input | 1 | Matched entry's dirty flag |
| tlb_way | input | WW | Way that produced the match |
| cur_pc | input | AW | Address of the accessing instruction |
| in_dslot | input | 1 | Instruction sits in a delay slot |
| br_pc | input | AW | Address of the related delayed branch |
| sr_in | input | 32 | Current status word |
| vbr | input | AW | Vector base |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Target register of the software write |
| sw_wdata | input | AW | Software write data |
| ldtlb | input | 1 | TLB load command |
| exc_taken | output | 1 | One-cycle exception entry pulse |
| redir_pc | output | AW | Fetch redirect target |
| sr_out | output | 32 | Updated status word to install |
| saved_sr | output | 32 | Saved status word |
| saved_pc | output | AW | Saved PC |
| evt_code | output | 12 | Exception event code |
| fault_addr | output | AW | Faulting logical address |
| ent_hi | output | AW | Entry-high word (page number) |
| ent_lo | output | AW | Entry-low word (frame and flags) |
| repl_way | output | WW | Replacement way index |
| tlb_we | output | 1 | TLB write strobe |
| tlb_wway | output | WW | Way to write |
| tlb_hi | output | AW | Entry-high data for the TLB |
| tlb_lo | output | AW | Entry-low data for the TLB |

## Verification
The stimulus is a stream of accesses that crosses every lookup outcome: reads, misses, invalid entries, rights failures, dirty hits and clean write hits. Only the last should fault, so any loosened term in the qualifier shows up. Faults are issued both with and without the delay-slot flag, which tells the two saved-PC sources apart. They are also issued with the mask bit set and cleared, which separates masked requests from taken ones, and back to back, which shows whether the pulse repeats per access. Software writes land in the same cycle as faults to expose the capture priority. Load commands follow both paths, so the presented way and entry words are seen after each writer.

// File: rtl/wfault_entry.sv
module wfault_entry #(
  parameter int AW      = 32,
  parameter int PG      = 10,
  parameter int WAYS    = 4,
  parameter int MD_BIT  = 30,
  parameter int RB_BIT  = 29,
  parameter int BL_BIT  = 28,
  parameter logic [11:0] CODE = 12'h080,
  parameter logic [31:0] VOFS = 32'h0000_0100,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_vld,
  input  logic          acc_wr,
  input  logic [AW-1:0] acc_addr,
  input  logic          tlb_hit,
  input  logic          tlb_valid,
  input  logic          tlb_rights_ok,
  input  logic          tlb_dirty,
  input  logic [WW-1:0] tlb_way,
  input  logic [AW-1:0] cur_pc,
  input  logic          in_dslot,
  input  logic [AW-1:0] br_pc,
  input  logic [31:0]   sr_in,
  input  logic [AW-1:0] vbr,
  input  logic          sw_we,
  input  logic [1:0]    sw_sel,
  input  logic [AW-1:0] sw_wdata,
  input  logic          ldtlb,
  output logic          exc_taken,
  output logic [AW-1:0] redir_pc,
  output logic [31:0]   sr_out,
  output logic [31:0]   saved_sr,
  output logic [AW-1:0] saved_pc,
  output logic [11:0]   evt_code,
  output logic [AW-1:0] fault_addr,
  output logic [AW-1:0] ent_hi,
  output logic [AW-1:0] ent_lo,
  output logic [WW-1:0] repl_way,
  output logic          tlb_we,
  output logic [WW-1:0] tlb_wway,
  output logic [AW-1:0] tlb_hi,
  output logic [AW-1:0] tlb_lo
);

  localparam logic [31:0] FORCE = (32'd1 << MD_BIT) | (32'd1 << RB_BIT) | (32'd1 << BL_BIT);

  logic clean_hit, fault;
  assign clean_hit = tlb_hit & tlb_valid & tlb_rights_ok & ~tlb_dirty;
  assign fault     = acc_vld & acc_wr & clean_hit & ~sr_in[BL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_taken  <= 1'b0;
      redir_pc   <= '0;
      sr_out     <= '0;
      saved_sr   <= '0;
      saved_pc   <= '0;
      evt_code   <= '0;
      fault_addr <= '0;
      ent_hi     <= '0;
      ent_lo     <= '0;
      repl_way   <= '0;
    end else begin
      exc_taken <= fault;
      if (fault) begin
        ent_hi     <= {acc_addr[AW-1:PG], {PG{1'b0}}};
        fault_addr <= acc_addr;
        evt_code   <= CODE;
        saved_pc   <= in_dslot ? br_pc : cur_pc;
        saved_sr   <= sr_in;
        sr_out     <= sr_in | FORCE;
        repl_way   <= tlb_way;
        redir_pc   <= vbr + VOFS[AW-1:0];
      end else if (sw_we) begin
        if (sw_sel == 2'd0) ent_hi   <= sw_wdata;
        if (sw_sel == 2'd2) repl_way <= sw_wdata[WW-1:0];
      end
      if (sw_we && sw_sel == 2'd1) ent_lo <= sw_wdata;
    end
  end

  assign tlb_we   = ldtlb;
  assign tlb_wway = repl_way;
  assign tlb_hi   = ent_hi;
  assign tlb_lo   = ent_lo;

endmodule

module wfault_entry_chk #(
  parameter int AW     = 32,
  parameter int WW     = 2,
  parameter int BL_BIT = 28,
  parameter int MD_BIT = 30,
  parameter int RB_BIT = 29,
  parameter logic [11:0] CODE = 12'h080,
  parameter logic [31:0] VOFS = 32'h0000_0100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_vld,
  input logic          acc_wr,
  input logic [AW-1:0] acc_addr,
  input logic          tlb_hit,
  input logic          tlb_valid,
  input logic          tlb_rights_ok,
  input logic          tlb_dirty,
  input logic [WW-1:0] tlb_way,
  input logic [31:0]   sr_in,
  input logic [AW-1:0] vbr,
  input logic          sw_we,
  input logic          exc_taken,
  input logic [AW-1:0] redir_pc,
  input logic [31:0]   sr_out,
  input logic [31:0]   saved_sr,
  input logic [AW-1:0] saved_pc,
  input logic [11:0]   evt_code,
  input logic [AW-1:0] fault_addr,
  input logic [WW-1:0] repl_way
);

  logic req;
  assign req = acc_vld && acc_wr && tlb_hit && tlb_valid && tlb_rights_ok && !tlb_dirty && !sr_in[BL_BIT];

  p_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_wr) |=> !exc_taken);
  p_dirty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && tlb_dirty) |=> !exc_taken);
  p_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> exc_taken && fault_addr == $past(acc_addr));
  p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> evt_code == CODE);
  p_ssr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> saved_sr == $past(sr_in));
  p_sr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_taken |-> (sr_out[MD_BIT] && sr_out[RB_BIT] && sr_out[BL_BIT]));
  p_way_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> repl_way == $past(tlb_way));
  p_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> redir_pc == $past(vbr) + VOFS[AW-1:0]);
  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_in[BL_BIT] |=> !exc_taken);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_in[BL_BIT] && !sw_we) |=> ($stable(fault_addr) && $stable(saved_pc) && $stable(saved_sr) && $stable(repl_way)));
endmodule

bind wfault_entry wfault_entry_chk #(
  .AW(AW), .WW(WW), .BL_BIT(BL_BIT), .MD_BIT(MD_BIT), .RB_BIT(RB_BIT), .CODE(CODE), .VOFS(VOFS)
) u_chk (.*);

// File: tb/tb_wfault_entry.sv
module tb_wfault_entry;
  localparam int AW = 32;
  localparam int PG = 10;
  localparam int WW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_vld = 0, acc_wr = 0, tlb_hit = 0, tlb_valid = 0, tlb_rights_ok = 0, tlb_dirty = 0;
  logic [AW-1:0] acc_addr = '0, cur_pc = '0, br_pc = '0, vbr = '0, sw_wdata = '0;
  logic [WW-1:0] tlb_way = '0;
  logic in_dslot = 0, sw_we = 0, ldtlb = 0;
  logic [1:0] sw_sel = '0;
  logic [31:0] sr_in = '0;
  logic exc_taken, tlb_we;
  logic [AW-1:0] redir_pc, saved_pc, fault_addr, ent_hi, ent_lo, tlb_hi, tlb_lo;
  logic [31:0] sr_out, saved_sr;
  logic [11:0] evt_code;
  logic [WW-1:0] repl_way, tlb_wway;

  always #4 clk = ~clk;

  wfault_entry dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic m_exc;
  logic [31:0] m_rpc, m_srout, m_ssr, m_spc, m_tea, m_hi, m_lo;
  logic [11:0] m_code;
  logic [1:0] m_rc;
  string exc_tag;

  task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, nm, act, exp);
    end
  endtask

  task automatic cmp_regs();
    chk(exc_tag, "exc_taken", {31'd0, exc_taken}, {31'd0, m_exc});
    chk("R2", "ent_hi", ent_hi, m_hi);
    chk("R3", "fault_addr", fault_addr, m_tea);
    chk("R4", "evt_code", {20'd0, evt_code}, {20'd0, m_code});
    chk("R5", "saved_pc", saved_pc, m_spc);
    chk("R6", "saved_sr", saved_sr, m_ssr);
    chk("R7", "sr_out", sr_out, m_srout);
    chk("R8", "repl_way", {30'd0, repl_way}, {30'd0, m_rc});
    chk("R9", "redir_pc", redir_pc, m_rpc);
    chk("R12", "ent_lo", ent_lo, m_lo);
  endtask

  task automatic cmp_load();
    chk("R13", "tlb_we", {31'd0, tlb_we}, {31'd0, ldtlb});
    chk("R13", "tlb_wway", {30'd0, tlb_wway}, {30'd0, m_rc});
    chk("R13", "tlb_hi", tlb_hi, m_hi);
    chk("R13", "tlb_lo", tlb_lo, m_lo);
  endtask

  // advance the model over one clock edge from the currently driven inputs
  task automatic step_model();
    bit cand, f;
    cand = acc_vld && acc_wr && tlb_hit && tlb_valid && tlb_rights_ok && !tlb_dirty;
    f = cand && !sr_in[28];
    if (cand && sr_in[28]) exc_tag = "R10";
    else if (m_exc && !f) exc_tag = "R11";
    else exc_tag = "R1";
    m_exc = f;
    if (f) begin
      m_hi = (acc_addr >> PG) << PG;
      m_tea = acc_addr;
      m_code = 12'h080;
      m_spc = in_dslot ? br_pc : cur_pc;
      m_ssr = sr_in;
      m_srout = sr_in | 32'h7000_0000;
      m_rc = tlb_way;
      m_rpc = vbr + 32'h100;
    end else if (sw_we) begin
      if (sw_sel == 0) m_hi = sw_wdata;
      if (sw_sel == 2) m_rc = sw_wdata[1:0];
    end
    if (sw_we && sw_sel == 1) m_lo = sw_wdata;
  endtask

  task automatic cycle();
    #1 cmp_load();
    step_model();
    @(negedge clk);
    cmp_regs();
  endtask

  task automatic access(input bit v, input bit w, input bit h, input bit va, input bit ro, input bit d,
                        input logic [31:0] a, input logic [1:0] way, input bit ds);
    acc_vld = v; acc_wr = w; tlb_hit = h; tlb_valid = va; tlb_rights_ok = ro; tlb_dirty = d;
    acc_addr = a; tlb_way = way; in_dslot = ds;
    cur_pc = a ^ 32'h1357_0000; br_pc = a ^ 32'h2468_0002;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_exc = 0; m_rpc = 0; m_srout = 0; m_ssr = 0; m_spc = 0; m_tea = 0;
    m_hi = 0; m_lo = 0; m_code = 0; m_rc = 0; exc_tag = "R4";
    vbr = 32'h8000_0000; sr_in = 32'h0000_00F0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_regs();  // reset state, R4 code at zero

    // R1: each non-faulting lookup outcome
    access(1,0,1,1,1,0, 32'h1000_0404, 2'd1, 0); cycle();  // read
    access(1,1,0,1,1,0, 32'h1000_0808, 2'd1, 0); cycle();  // miss
    access(1,1,1,0,1,0, 32'h1000_0c0c, 2'd1, 0); cycle();  // invalid
    access(1,1,1,1,0,0, 32'h1000_1010, 2'd1, 0); cycle();  // rights fail
    access(1,1,1,1,1,1, 32'h1000_1414, 2'd1, 0); cycle();  // dirty
    access(0,1,1,1,1,0, 32'h1000_1818, 2'd1, 0); cycle();  // no access
    // R2..R9: clean write hit, not in delay slot
    access(1,1,1,1,1,0, 32'hABCD_E7F3, 2'd2, 0); cycle();
    // R10: masked while the status word has bit 28 set
    sr_in = m_srout;
    access(1,1,1,1,1,0, 32'h5555_5555, 2'd3, 1); cycle();
    access(0,0,0,0,0,0, 0, 0, 0); cycle();
    // R5 delay slot path, R11 back-to-back entries
    sr_in = 32'h0000_0003; vbr = 32'hFFFF_FF80;
    access(1,1,1,1,1,0, 32'h1234_5678, 2'd3, 1); cycle();
    access(1,1,1,1,1,0, 32'h8765_4321, 2'd0, 0); cycle();
    access(0,0,0,0,0,0, 0, 0, 0); cycle();
    // R12 software writes, priority against capture
    sw_we = 1; sw_sel = 1; sw_wdata = 32'hCAFE_F00D; cycle();
    sw_sel = 0; sw_wdata = 32'h0BAD_0000; cycle();
    sw_sel = 2; sw_wdata = 32'h0000_0002; cycle();
    sw_sel = 3; sw_wdata = 32'hFFFF_FFFF; cycle();
    sw_sel = 0; sw_wdata = 32'h1111_1111;
    access(1,1,1,1,1,0, 32'h4444_4C00, 2'd1, 0); cycle();
    sw_sel = 2; sw_wdata = 32'h3;
    access(1,1,1,1,1,0, 32'h4444_8C00, 2'd0, 0); cycle();
    sw_we = 0; access(0,0,0,0,0,0, 0, 0, 0);
    // R13 load command after both writer paths
    ldtlb = 1; cycle(); ldtlb = 0; cycle();

    // mixed stream with the status mask looped back
    for (int i = 0; i < 3000; i++) begin
      bit pick;
      pick = ($urandom_range(0, 3) == 0);
      access($urandom_range(0, 7) != 0, $urandom_range(0, 1), pick | $urandom_range(0, 1),
             pick | ($urandom_range(0, 5) != 0), pick | ($urandom_range(0, 5) != 0),
             pick ? 1'b0 : $urandom_range(0, 1), $urandom, 2'($urandom_range(0, 3)), $urandom_range(0, 1));
      vbr = $urandom;
      sw_we = ($urandom_range(0, 4) == 0); sw_sel = 2'($urandom_range(0, 3)); sw_wdata = $urandom;
      ldtlb = ($urandom_range(0, 5) == 0);
      if (m_exc) sr_in = m_srout;
      else if ($urandom_range(0, 4) == 0) sr_in = $urandom & 32'hEFFF_FFFF;
      cycle();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule